// File: doc/BRIEF.md
# Separable Bitmap Scaler

This block resizes a raster bitmap that arrives as a row-major pixel stream. Resizing happens in two separable passes. A horizontal pass turns each incoming source row into a row of destination width. A vertical pass then blends pairs of those intermediate rows into destination rows. Both axes can grow or shrink the image independently. Each size can be anything from 1 to the configured maximum, which is 1024 by default. One configuration bit selects the filter: nearest-point sampling or bilinear interpolation.

Software programs a 16.16 fixed-point step for each axis. The step is the source size divided by the destination size. Destination pixel k on an axis sits at source position k*step. In bilinear mode, the top four fractional bits of that position weight the two neighbouring source samples. A neighbour past the last column or row is replaced by the edge sample. A pixel holds one or more 8-bit channels, and each channel is filtered on its own.

The input side uses valid/ready flow control. It carries a start-of-frame flag on the first pixel and an end-of-line flag on the last pixel of every source row, so the source width is taken from the stream. The output is a registered valid stream. It flags the last pixel of each destination row and the last pixel of the frame. The vertical pass keeps its intermediate rows in an internal line store.

Top module: `bitmap_scaler`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Every destination row is exactly `cfg_dst_w` output beats long, and `out_eol` is 1 on its last beat only.
- R3: A frame yields `cfg_dst_h` rows. `out_eof` is 1 (together with `out_eol`) on the final beat of the frame only.
- R4: With `cfg_bilinear`=0, output pixel (row j, column i) equals source pixel (min(floor(j*step_y), H-1), min(floor(i*step_x), W-1)). Here floor takes the integer part of the 16.16 product, and W and H are the source width and height.
- R5: With `cfg_bilinear`=1, each pass computes (a*(16-w)+b*w)>>4, truncated. Here w is bits [15:12] of the 16.16 position, a is the sample at floor(position), and b is the sample one step further on.
- R6: The horizontal pass runs first. The vertical pass interpolates between the truncated 8-bit results of the horizontal pass.
- R7: A neighbour index past the last source column or row is clamped to that last column or row.
- R8: Enlarging and shrinking both work, on either axis and in any combination.
- R9: Channel c occupies bits [c*8 +: 8] of a pixel, and each channel is filtered independently of the others.
- R10: An accepted pixel with `in_sof`=1 restarts the frame at source row 0 and column 0. A partial row discarded this way produces no output.
- R11: Sizes of 1 and destination widths equal to the maximum dimension are handled.
- R12: `cfg_bilinear` encodes the filter: 0 selects point sampling, 1 selects bilinear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bilinear | input | 1 | Filter select: 0 point, 1 bilinear |
| cfg_src_h | input | CNT_W | Source rows per frame |
| cfg_dst_w | input | CNT_W | Destination pixels per row |
| cfg_dst_h | input | CNT_W | Destination rows per frame |
| cfg_step_x | input | STEP_W | Horizontal step, 16.16 source/destination ratio |
| cfg_step_y | input | STEP_W | Vertical step, 16.16 source/destination ratio |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Input pixel accepted on this edge when valid |
| in_data | input | PIX_W*CHANNELS | Input pixel, channels packed |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a source row |
| out_valid | output | 1 | Output pixel present |
| out_data | output | PIX_W*CHANNELS | Output pixel, channels packed |
| out_eol | output | 1 | Last pixel of a destination row |
| out_eof | output | 1 | Last pixel of the frame |

## Verification
The bench builds the scaler with a maximum dimension of 32 and two channels per pixel. The small maximum lets a full-width destination row, which is the address boundary of the line store, run in a few hundred cycles. The two channels expose any mixing between channel lanes. The frames mix enlargement and reduction on each axis with both filters, including 1x1 sources and destinations, where every neighbour is an edge clamp. A start-of-frame restart after a partial row is also exercised.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  localparam int FRAC_W = 16;
  localparam int WGT_W  = 4;

  typedef enum logic [1:0] {H_TAKE, H_EMIT, H_HOLD} h_state_t;
  typedef enum logic [1:0] {V_IDLE, V_RUN, V_DONE} v_state_t;
endpackage

// File: rtl/scaler_lerp.sv
module scaler_lerp #(
  parameter int PIX_W    = 8,
  parameter int CHANNELS = 1,
  parameter int WGT_W    = 4
) (
  input  logic [PIX_W*CHANNELS-1:0] a,
  input  logic [PIX_W*CHANNELS-1:0] b,
  input  logic [WGT_W-1:0]          w,
  output logic [PIX_W*CHANNELS-1:0] y
);
  localparam int SUM_W = PIX_W + WGT_W + 1;
  localparam logic [SUM_W-1:0] UNITY = SUM_W'(1) << WGT_W;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [SUM_W-1:0] ea, eb, wa, wb, sum;
    assign ea  = SUM_W'(a[c*PIX_W +: PIX_W]);
    assign eb  = SUM_W'(b[c*PIX_W +: PIX_W]);
    assign wb  = SUM_W'(w);
    assign wa  = UNITY - wb;
    assign sum = ea * wa + eb * wb;
    assign y[c*PIX_W +: PIX_W] = sum[WGT_W +: PIX_W];
  end
endmodule

// File: rtl/scaler_line_ram.sv
module scaler_line_ram #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/scaler_hpass.sv
module scaler_hpass
  import scaler_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int CHANNELS = 1,
  parameter int CNT_W    = 11,
  parameter int ADDR_W   = 10,
  parameter int STEP_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [PIX_W*CHANNELS-1:0] in_data,
  input  logic                      in_sof,
  input  logic                      in_eol,
  input  logic                      bilinear,
  input  logic [CNT_W-1:0]          dst_w,
  input  logic [STEP_W-1:0]         step,
  input  logic                      release_row,
  output logic                      row_rdy,
  output logic                      wr_en,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [PIX_W*CHANNELS-1:0] wr_data
);
  localparam int DATA_W = PIX_W * CHANNELS;
  localparam int POS_W  = STEP_W + CNT_W;
  localparam int INT_W  = POS_W - FRAC_W;

  h_state_t          st;
  logic [DATA_W-1:0] prev_px, cur_px;
  logic [CNT_W-1:0]  xi, xcnt, hj;
  logic              last_px;
  logic [POS_W-1:0]  hpos;

  logic [INT_W-1:0]  flo1, xi_ext;
  logic              fire, use_prev;
  logic [WGT_W-1:0]  wgt;

  assign flo1     = hpos[POS_W-1:FRAC_W] + INT_W'(1);
  assign xi_ext   = INT_W'(xi);
  assign fire     = (st == H_EMIT) && (hj < dst_w) && (last_px || (flo1 <= xi_ext));
  assign use_prev = (flo1 == xi_ext);
  assign wgt      = bilinear ? hpos[FRAC_W-1 -: WGT_W] : '0;

  assign in_ready = (st == H_TAKE);
  assign row_rdy  = (st == H_HOLD);
  assign wr_en    = fire;
  assign wr_addr  = hj[ADDR_W-1:0];

  scaler_lerp #(.PIX_W(PIX_W), .CHANNELS(CHANNELS), .WGT_W(WGT_W)) u_hlerp (
    .a (use_prev ? prev_px : cur_px),
    .b (cur_px),
    .w (wgt),
    .y (wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= H_TAKE;
      prev_px <= '0;
      cur_px  <= '0;
      xi      <= '0;
      xcnt    <= '0;
      hj      <= '0;
      hpos    <= '0;
      last_px <= 1'b0;
    end else begin
      case (st)
        H_TAKE: if (in_valid) begin
          prev_px <= cur_px;
          cur_px  <= in_data;
          last_px <= in_eol;
          st      <= H_EMIT;
          if (in_sof) begin
            xi   <= '0;
            xcnt <= in_eol ? '0 : CNT_W'(1);
            hj   <= '0;
            hpos <= '0;
          end else begin
            xi   <= xcnt;
            xcnt <= in_eol ? '0 : xcnt + CNT_W'(1);
          end
        end
        H_EMIT: begin
          if (fire) begin
            hj   <= hj + CNT_W'(1);
            hpos <= hpos + POS_W'(step);
          end else begin
            st <= last_px ? H_HOLD : H_TAKE;
          end
        end
        H_HOLD: if (release_row) begin
          st   <= H_TAKE;
          hj   <= '0;
          hpos <= '0;
        end
        default: st <= H_TAKE;
      endcase
    end
  end
endmodule

// File: rtl/bitmap_scaler.sv
module bitmap_scaler
  import scaler_pkg::*;
#(
  parameter int MAX_DIM  = 1024,
  parameter int PIX_W    = 8,
  parameter int CHANNELS = 1,
  parameter int STEP_W   = 32,
  parameter int CNT_W    = $clog2(MAX_DIM + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_bilinear,
  input  logic [CNT_W-1:0]          cfg_src_h,
  input  logic [CNT_W-1:0]          cfg_dst_w,
  input  logic [CNT_W-1:0]          cfg_dst_h,
  input  logic [STEP_W-1:0]         cfg_step_x,
  input  logic [STEP_W-1:0]         cfg_step_y,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [PIX_W*CHANNELS-1:0] in_data,
  input  logic                      in_sof,
  input  logic                      in_eol,
  output logic                      out_valid,
  output logic [PIX_W*CHANNELS-1:0] out_data,
  output logic                      out_eol,
  output logic                      out_eof
);
  localparam int ADDR_W = $clog2(MAX_DIM);
  localparam int DATA_W = PIX_W * CHANNELS;
  localparam int POS_W  = STEP_W + CNT_W;
  localparam int INT_W  = POS_W - FRAC_W;
  localparam int BANKS  = 2;

  // horizontal pass
  logic              h_we, h_row_rdy, v_release;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_data;

  scaler_hpass #(
    .PIX_W(PIX_W), .CHANNELS(CHANNELS), .CNT_W(CNT_W),
    .ADDR_W(ADDR_W), .STEP_W(STEP_W)
  ) u_hpass (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol),
    .bilinear(cfg_bilinear), .dst_w(cfg_dst_w), .step(cfg_step_x),
    .release_row(v_release), .row_rdy(h_row_rdy),
    .wr_en(h_we), .wr_addr(h_addr), .wr_data(h_data)
  );

  // vertical pass state
  v_state_t          vst;
  logic [CNT_W-1:0]  y, vj, xo;
  logic [POS_W-1:0]  vpos;
  logic [INT_W-1:0]  vflo1, y_ext;
  logic              last_row, vfire, row_end;

  assign vflo1    = vpos[POS_W-1:FRAC_W] + INT_W'(1);
  assign y_ext    = INT_W'(y);
  assign last_row = (y == cfg_src_h - CNT_W'(1));
  assign vfire    = (vst == V_RUN) && (vj < cfg_dst_h) && (last_row || (vflo1 <= y_ext));
  assign row_end  = (xo == cfg_dst_w - CNT_W'(1));
  assign v_release = (vst == V_DONE);

  // two-row line store, row parity selects the bank
  logic [DATA_W-1:0] rd_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    scaler_line_ram #(.DEPTH(MAX_DIM), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk(clk),
      .we(h_we && (y[0] == 1'(b))),
      .waddr(h_addr), .wdata(h_data),
      .raddr(xo[ADDR_W-1:0]),
      .rdata(rd_q[b])
    );
  end

  // read stage bookkeeping
  logic             s1_v, s1_prev, s1_bank, s1_eol, s1_eof;
  logic [WGT_W-1:0] s1_w;
  logic [DATA_W-1:0] row_a, row_b, v_pix;

  assign row_b = rd_q[s1_bank];
  assign row_a = s1_prev ? rd_q[~s1_bank] : row_b;

  scaler_lerp #(.PIX_W(PIX_W), .CHANNELS(CHANNELS), .WGT_W(WGT_W)) u_vlerp (
    .a(row_a), .b(row_b), .w(s1_w), .y(v_pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vst       <= V_IDLE;
      y         <= '0;
      vj        <= '0;
      xo        <= '0;
      vpos      <= '0;
      s1_v      <= 1'b0;
      s1_prev   <= 1'b0;
      s1_bank   <= 1'b0;
      s1_eol    <= 1'b0;
      s1_eof    <= 1'b0;
      s1_w      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eol   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      case (vst)
        V_IDLE: if (h_row_rdy) begin
          vst <= V_RUN;
          xo  <= '0;
        end
        V_RUN: begin
          if (vfire) begin
            xo <= row_end ? '0 : xo + CNT_W'(1);
            if (row_end) begin
              vj   <= vj + CNT_W'(1);
              vpos <= vpos + POS_W'(cfg_step_y);
            end
          end else begin
            vst <= V_DONE;
          end
        end
        V_DONE: begin
          vst <= V_IDLE;
          if (last_row) begin
            y    <= '0;
            vj   <= '0;
            vpos <= '0;
          end else begin
            y <= y + CNT_W'(1);
          end
        end
        default: vst <= V_IDLE;
      endcase

      if (in_valid && in_ready && in_sof) begin
        y    <= '0;
        vj   <= '0;
        vpos <= '0;
      end

      s1_v    <= vfire;
      s1_prev <= (vflo1 == y_ext);
      s1_bank <= y[0];
      s1_w    <= cfg_bilinear ? vpos[FRAC_W-1 -: WGT_W] : '0;
      s1_eol  <= row_end;
      s1_eof  <= row_end && (vj == cfg_dst_h - CNT_W'(1));

      out_valid <= s1_v;
      out_eol   <= s1_v && s1_eol;
      out_eof   <= s1_v && s1_eof;
      if (s1_v) out_data <= v_pix;
    end
  end
endmodule

// File: rtl/scaler_checker.sv
module scaler_checker #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_eol,
  input logic             out_eof,
  input logic [CNT_W-1:0] cfg_dst_w,
  input logic [CNT_W-1:0] cfg_dst_h
);
  logic [CNT_W-1:0] pix_in_row, rows_in_frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_in_row    <= '0;
      rows_in_frame <= '0;
    end else if (out_valid) begin
      pix_in_row <= out_eol ? '0 : pix_in_row + CNT_W'(1);
      if (out_eol) rows_in_frame <= out_eof ? '0 : rows_in_frame + CNT_W'(1);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && in_ready));

  assert_eol_has_valid_R2: assert property (@(posedge clk) disable iff (rst)
    out_eol |-> out_valid);

  assert_row_length_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eol) |-> (pix_in_row == cfg_dst_w - CNT_W'(1)));

  assert_eof_on_eol_R3: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> (out_eol && out_valid));

  assert_frame_rows_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eof) |-> (rows_in_frame == cfg_dst_h - CNT_W'(1)));
endmodule

bind bitmap_scaler scaler_checker #(.CNT_W(CNT_W)) u_scaler_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready),
  .out_valid(out_valid), .out_eol(out_eol), .out_eof(out_eof),
  .cfg_dst_w(cfg_dst_w), .cfg_dst_h(cfg_dst_h)
);

// File: tb/test_bitmap_scaler.sv
`timescale 1ns/1ps
module test_bitmap_scaler;
  localparam int MAXD  = 32;
  localparam int CH    = 2;
  localparam int PW    = 8;
  localparam int SW_W  = 32;
  localparam int CW    = $clog2(MAXD + 1);
  localparam int DW    = CH * PW;
  localparam int NVEC  = 8;
  // sw, sh, dw, dh, bilinear
  localparam int VEC [0:NVEC-1][0:4] = '{
    '{8, 6, 8, 6, 0},
    '{8, 6, 16, 12, 1},
    '{16, 8, 5, 3, 1},
    '{7, 5, 11, 4, 0},
    '{6, 4, 13, 9, 1},
    '{1, 1, 4, 3, 1},
    '{9, 7, 1, 1, 0},
    '{32, 3, 32, 2, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_bilinear = 1'b0;
  logic [CW-1:0] cfg_src_h = '0, cfg_dst_w = '0, cfg_dst_h = '0;
  logic [SW_W-1:0] cfg_step_x = '0, cfg_step_y = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_eol, out_eof;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  bitmap_scaler #(.MAX_DIM(MAXD), .PIX_W(PW), .CHANNELS(CH), .STEP_W(SW_W)) i_bitmap_scaler (
    .clk(clk), .rst(rst), .cfg_bilinear(cfg_bilinear), .cfg_src_h(cfg_src_h),
    .cfg_dst_w(cfg_dst_w), .cfg_dst_h(cfg_dst_h), .cfg_step_x(cfg_step_x),
    .cfg_step_y(cfg_step_y), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol), .out_valid(out_valid),
    .out_data(out_data), .out_eol(out_eol), .out_eof(out_eof)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int src [0:CH*MAXD*MAXD-1];
  logic [DW-1:0] cap_d [0:1023];
  bit cap_eol [0:1023];
  bit cap_eof [0:1023];
  int ncap = 0;

  always @(negedge clk) begin
    if (!rst && out_valid && ncap < 1024) begin
      cap_d[ncap]   = out_data;
      cap_eol[ncap] = out_eol;
      cap_eof[ncap] = out_eof;
      ncap++;
    end
  end

  function automatic int sidx(int c, int y, int x);
    return c * MAXD * MAXD + y * MAXD + x;
  endfunction

  function automatic int clampi(int v, int hi);
    return (v > hi) ? hi : v;
  endfunction

  function automatic int hval(int c, int y, int i, int sw, int stx, int bil);
    longint p = longint'(i) * stx;
    int f = int'(p >>> 16);
    int w = bil ? int'((p >>> 12) & 15) : 0;
    int a = src[sidx(c, y, clampi(f, sw - 1))];
    int b = src[sidx(c, y, clampi(f + 1, sw - 1))];
    return (a * (16 - w) + b * w) >>> 4;
  endfunction

  function automatic int pval(int c, int j, int i, int sw, int sh, int stx, int sty, int bil);
    longint q = longint'(j) * sty;
    int g = int'(q >>> 16);
    int w = bil ? int'((q >>> 12) & 15) : 0;
    int a = hval(c, clampi(g, sh - 1), i, sw, stx, bil);
    int b = hval(c, clampi(g + 1, sh - 1), i, sw, stx, bil);
    return (a * (16 - w) + b * w) >>> 4;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fill_src(int sw, int sh, int seed);
    for (int c = 0; c < CH; c++)
      for (int y = 0; y < sh; y++)
        for (int x = 0; x < sw; x++)
          src[sidx(c, y, x)] = (x * 29 + y * 53 + c * 101 + seed * 17) & 255;
  endtask

  // called and returns at a falling edge
  task automatic send_pix(logic [DW-1:0] d, bit sof, bit eol);
    in_valid = 1'b1;
    in_data  = d;
    in_sof   = sof;
    in_eol   = eol;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eol   = 1'b0;
  endtask

  function automatic logic [DW-1:0] src_word(int y, int x);
    logic [DW-1:0] d;
    for (int c = 0; c < CH; c++) d[c*PW +: PW] = PW'(src[sidx(c, y, x)]);
    return d;
  endfunction

  task automatic run_frame(int sw, int sh, int dw, int dh, int bil, int seed, string tag);
    int need = dw * dh;
    int t = 0;
    int stx = (sw << 16) / dw;
    int sty = (sh << 16) / dh;
    bit data_ok = 1, eol_ok = 1, eof_ok = 1;
    int bad_act = 0, bad_exp = 0, bad_k = 0, eol_k = 0, eof_k = 0;
    fill_src(sw, sh, seed);
    cfg_bilinear = bil[0];
    cfg_src_h  = CW'(sh);
    cfg_dst_w  = CW'(dw);
    cfg_dst_h  = CW'(dh);
    cfg_step_x = SW_W'(stx);
    cfg_step_y = SW_W'(sty);
    ncap = 0;
    for (int y = 0; y < sh; y++)
      for (int x = 0; x < sw; x++) begin
        if (((y * sw + x) % 7) == 3) @(negedge clk);
        send_pix(src_word(y, x), (x == 0) && (y == 0), x == sw - 1);
      end
    while (ncap < need && t < 4000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
    check(ncap == need, "R2 R3", {tag, " beat count"}, ncap, need);
    for (int k = 0; k < need && k < ncap; k++) begin
      int j = k / dw;
      int i = k % dw;
      for (int c = 0; c < CH; c++) begin
        int e = pval(c, j, i, sw, sh, stx, sty, bil);
        int a = int'(cap_d[k][c*PW +: PW]);
        if (data_ok && a != e) begin
          data_ok = 0; bad_act = a; bad_exp = e; bad_k = k;
        end
      end
      if (eol_ok && cap_eol[k] != (i == dw - 1)) begin eol_ok = 0; eol_k = k; end
      if (eof_ok && cap_eof[k] != (k == need - 1)) begin eof_ok = 0; eof_k = k; end
    end
    check(data_ok, bil ? "R5 R6 R12 R7 R8 R9" : "R4 R12 R7 R8 R9",
          $sformatf("%s pixel %0d", tag, bad_k), bad_act, bad_exp);
    check(eol_ok, "R2", $sformatf("%s eol at beat %0d", tag, eol_k), int'(cap_eol[eol_k]), int'(!cap_eol[eol_k]));
    check(eof_ok, "R3", $sformatf("%s eof at beat %0d", tag, eof_k), int'(cap_eof[eof_k]), int'(!cap_eof[eof_k]));
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 R3: actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    for (int v = 0; v < NVEC; v++)
      run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], v,
                $sformatf("vector %0d", v));

    // R11: single pixel in, single pixel out
    run_frame(1, 1, 1, 1, 0, 11, "R11 1x1 to 1x1");

    // R10: abandoned partial row, then a restart with sof
    cfg_dst_w = CW'(3);
    cfg_dst_h = CW'(6);
    cfg_src_h = CW'(4);
    cfg_step_x = SW_W'((5 << 16) / 3);
    cfg_step_y = SW_W'((4 << 16) / 6);
    ncap = 0;
    send_pix(16'h1234, 1'b1, 1'b0);
    send_pix(16'h5678, 1'b0, 1'b0);
    send_pix(16'h9abc, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(ncap == 0, "R10", "output from partial row", ncap, 0);
    run_frame(5, 4, 3, 6, 1, 21, "R10 restart frame");

    // R1: reset in the middle of a row
    send_pix(16'h0102, 1'b1, 1'b0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after mid-row reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid after mid-row reset", int'(out_valid), 0);
    run_frame(4, 3, 7, 5, 1, 31, "R8 after reset");

    finish_run();
  end
endmodule